// File: doc/BRIEF.md
# PTP Event Header Field Extractor

This block watches the bytes of an Ethernet frame as they stream past and finds where the precision time protocol header begins. The header may follow the Ethernet header directly, or it may sit behind an IPv4/UDP or an IPv6/UDP stack. In every case an optional single VLAN tag may come first. The block pulls out the following fields:

- the message-type nibble;
- the 64-bit clock identity;
- the 16-bit port number;
- the 16-bit sequence id.

It also marks the frame as a one-step correction candidate when the message is a sync or a peer-delay response.

The stream carries a byte, a valid qualifier and start/end-of-frame markers. The encapsulation kind and the VLAN presence are given alongside the first byte of each frame. Each frame yields exactly one result strobe. The strobe carries either the fields, or an error flag when the frame is too short or its encapsulation is unknown. The block does not check checksums and does not modify frames.

Top module: `ptp_hdr_extract`

## Requirements
- R1: With encapsulation code 0 (raw Ethernet), the PTP header starts at frame byte 14 (byte 0 carries the start marker).
- R2: When the VLAN flag is high with the first byte, every header start offset moves 4 bytes later.
- R3: With encapsulation code 1 (IPv4/UDP), the header starts at 14 + 4*N + 8, where N is the low nibble of frame byte 14 (byte 18 when tagged).
- R4: With encapsulation code 2 (IPv6/UDP), the header starts at byte 62.
- R5: The message type is the low nibble of header byte 0. The clock identity is header bytes 20..27, the port number is bytes 28..29 and the sequence id is bytes 30..31. All are big-endian, with the first byte most significant.
- R6: The result strobe rises for one cycle, in the cycle after the clock edge that takes header byte 31, with the error flag low. Later bytes of that frame, including its end marker, produce no further result.
- R7: A frame whose end marker arrives before header byte 31 gives one strobe, in the cycle after the end byte. That strobe has the error flag high, all fields zero and the candidate flag low.
- R8: Encapsulation code 3 is unknown and always yields an error result at the end of the frame.
- R9: The one-step candidate flag is high on a good result only for message type 0 (sync) or 3 (peer-delay response).
- R10: Bytes with valid low, and valid bytes outside a frame (before a start marker), are ignored. Encapsulation and VLAN inputs matter only with the start byte.
- R11: After reset the strobe is low and all result fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte qualifier |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_data | input | 8 | Frame byte |
| in_encap | input | 2 | Encapsulation kind: 0 raw, 1 IPv4/UDP, 2 IPv6/UDP, 3 unknown |
| in_vlan | input | 1 | One VLAN tag present |
| res_valid | output | 1 | Result strobe |
| res_error | output | 1 | Frame too short or encapsulation unknown |
| res_msg_type | output | 4 | Message-type nibble |
| res_clock_id | output | 64 | Clock identity |
| res_port_num | output | 16 | Port number |
| res_seq_id | output | 16 | Sequence id |
| res_one_step | output | 1 | Sync or peer-delay response |

## Verification
The properties assume that start and end markers only come with valid bytes. They also assume that a frame's position count never passes 255 before its header completes, so every result strobe is caused by a valid byte in the cycle before. The stimulus keeps to this: every frame is at most 130 bytes, and it marks only its first and last bytes. Markers are raised during idle gap cycles only while valid is low, which exercises R10 without leaving those assumptions.

// File: rtl/ptp_hx_pkg.sv
package ptp_hx_pkg;
  typedef enum logic [1:0] {
    ENC_RAW  = 2'd0,
    ENC_IPV4 = 2'd1,
    ENC_IPV6 = 2'd2,
    ENC_RSVD = 2'd3
  } encap_e;

  localparam int ETH_LEN   = 14;
  localparam int VLAN_LEN  = 4;
  localparam int UDP_LEN   = 8;
  localparam int IP6_LEN   = 40;
  localparam int OFF_CLK   = 20;
  localparam int OFF_PORT  = 28;
  localparam int OFF_SEQ   = 30;
  localparam int HDR_LAST  = 31;

  typedef struct packed {
    logic [3:0]  msg;
    logic [63:0] clk_id;
    logic [15:0] port;
    logic [15:0] seq;
  } ptp_fields_t;
endpackage

// File: rtl/ptp_hx_offset.sv
module ptp_hx_offset
  import ptp_hx_pkg::*;
#(
  parameter int POS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             beat,
  input  logic             sof,
  input  logic [3:0]       ihl_nib,
  input  encap_e           encap_in,
  input  logic             vlan_in,
  input  logic [POS_W-1:0] cur_pos,
  output logic             hdr_known,
  output logic [POS_W-1:0] hdr_start
);
  localparam logic [POS_W-1:0] L_ETH  = POS_W'(ETH_LEN);
  localparam logic [POS_W-1:0] L_VLAN = POS_W'(VLAN_LEN);
  localparam logic [POS_W-1:0] L_UDP  = POS_W'(UDP_LEN);
  localparam logic [POS_W-1:0] L_IP6  = POS_W'(ETH_LEN + IP6_LEN + UDP_LEN);

  encap_e           encap_q, cur_encap;
  logic             vlan_q, cur_vlan, known_q;
  logic [POS_W-1:0] start_q, base, ihl_pos;

  assign cur_encap = sof ? encap_in : encap_q;
  assign cur_vlan  = sof ? vlan_in  : vlan_q;
  assign base      = cur_vlan ? L_VLAN : '0;
  assign ihl_pos   = base + L_ETH;

  always_comb begin
    case (cur_encap)
      ENC_RAW:  begin hdr_known = 1'b1;            hdr_start = base + L_ETH; end
      ENC_IPV6: begin hdr_known = 1'b1;            hdr_start = base + L_IP6; end
      ENC_IPV4: begin hdr_known = known_q & ~sof;  hdr_start = start_q;      end
      default:  begin hdr_known = 1'b0;            hdr_start = '0;           end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      encap_q <= ENC_RSVD;
      vlan_q  <= 1'b0;
      known_q <= 1'b0;
      start_q <= '0;
    end else if (beat) begin
      encap_q <= cur_encap;
      vlan_q  <= cur_vlan;
      if (sof) begin
        known_q <= 1'b0;
      end else if (cur_encap == ENC_IPV4 && !known_q && cur_pos == ihl_pos) begin
        known_q <= 1'b1;
        start_q <= ihl_pos + L_UDP + POS_W'({ihl_nib, 2'b00});
      end
    end
  end
endmodule

// File: rtl/ptp_hx_capture.sv
module ptp_hx_capture
  import ptp_hx_pkg::*;
#(
  parameter int POS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             beat,
  input  logic             eof,
  input  logic [7:0]       data,
  input  logic [POS_W-1:0] cur_pos,
  input  logic             hdr_known,
  input  logic [POS_W-1:0] hdr_start,
  output logic             finish,
  output logic             res_valid,
  output logic             res_error,
  output ptp_fields_t      res_fields,
  output logic             res_one_step
);
  localparam logic [POS_W-1:0] R_CLK0 = POS_W'(OFF_CLK);
  localparam logic [POS_W-1:0] R_CLK7 = POS_W'(OFF_CLK + 7);
  localparam logic [POS_W-1:0] R_PRT0 = POS_W'(OFF_PORT);
  localparam logic [POS_W-1:0] R_PRT1 = POS_W'(OFF_PORT + 1);
  localparam logic [POS_W-1:0] R_SEQ0 = POS_W'(OFF_SEQ);
  localparam logic [POS_W-1:0] R_LAST = POS_W'(HDR_LAST);

  logic [POS_W-1:0] rel;
  logic             in_hdr;
  logic [3:0]       msg_q;
  logic [63:0]      clk_q;
  logic [15:0]      port_q;
  logic [7:0]       seq_hi_q;

  assign rel    = cur_pos - hdr_start;
  assign in_hdr = hdr_known && (cur_pos >= hdr_start) && (rel <= R_LAST);
  assign finish = beat && in_hdr && (rel == R_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_q        <= '0;
      clk_q        <= '0;
      port_q       <= '0;
      seq_hi_q     <= '0;
      res_valid    <= 1'b0;
      res_error    <= 1'b0;
      res_fields   <= '0;
      res_one_step <= 1'b0;
    end else begin
      res_valid <= beat && (finish || eof);
      if (beat && in_hdr) begin
        if (rel == '0)                        msg_q    <= data[3:0];
        if (rel >= R_CLK0 && rel <= R_CLK7)   clk_q    <= {clk_q[55:0], data};
        if (rel == R_PRT0 || rel == R_PRT1)   port_q   <= {port_q[7:0], data};
        if (rel == R_SEQ0)                    seq_hi_q <= data;
      end
      if (finish) begin
        res_error    <= 1'b0;
        res_fields   <= '{msg: msg_q, clk_id: clk_q, port: port_q, seq: {seq_hi_q, data}};
        res_one_step <= (msg_q == 4'd0) || (msg_q == 4'd3);
      end else if (beat && eof) begin
        res_error    <= 1'b1;
        res_fields   <= '0;
        res_one_step <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ptp_hdr_extract.sv
module ptp_hdr_extract
  import ptp_hx_pkg::*;
#(
  parameter int POS_W = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic        in_sof,
  input  logic        in_eof,
  input  logic [7:0]  in_data,
  input  logic [1:0]  in_encap,
  input  logic        in_vlan,
  output logic        res_valid,
  output logic        res_error,
  output logic [3:0]  res_msg_type,
  output logic [63:0] res_clock_id,
  output logic [15:0] res_port_num,
  output logic [15:0] res_seq_id,
  output logic        res_one_step
);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic             beat, live_q, finish, hdr_known;
  logic [POS_W-1:0] pos_q, cur_pos, hdr_start;
  ptp_fields_t      fields;

  assign beat    = in_valid && (in_sof || live_q);
  assign cur_pos = in_sof ? '0 : pos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q  <= '0;
      live_q <= 1'b0;
    end else if (beat) begin
      pos_q  <= (cur_pos == POS_MAX) ? cur_pos : cur_pos + 1'b1;
      live_q <= !in_eof && !finish;
    end
  end

  ptp_hx_offset #(.POS_W(POS_W)) u_offset (
    .clk       (clk),
    .rst       (rst),
    .beat      (beat),
    .sof       (in_sof),
    .ihl_nib   (in_data[3:0]),
    .encap_in  (encap_e'(in_encap)),
    .vlan_in   (in_vlan),
    .cur_pos   (cur_pos),
    .hdr_known (hdr_known),
    .hdr_start (hdr_start)
  );

  ptp_hx_capture #(.POS_W(POS_W)) u_capture (
    .clk          (clk),
    .rst          (rst),
    .beat         (beat),
    .eof          (in_eof),
    .data         (in_data),
    .cur_pos      (cur_pos),
    .hdr_known    (hdr_known),
    .hdr_start    (hdr_start),
    .finish       (finish),
    .res_valid    (res_valid),
    .res_error    (res_error),
    .res_fields   (fields),
    .res_one_step (res_one_step)
  );

  assign res_msg_type = fields.msg;
  assign res_clock_id = fields.clk_id;
  assign res_port_num = fields.port;
  assign res_seq_id   = fields.seq;
endmodule

// File: rtl/ptp_hdr_extract_chk.sv
module ptp_hdr_extract_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_sof,
  input logic        in_eof,
  input logic        res_valid,
  input logic        res_error,
  input logic [3:0]  res_msg_type,
  input logic [63:0] res_clock_id,
  input logic [15:0] res_port_num,
  input logic [15:0] res_seq_id,
  input logic        res_one_step
);
  AST_ERR_FIELDS_ZERO: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_error |-> res_msg_type == 4'd0 && res_clock_id == 64'd0 &&
    res_port_num == 16'd0 && res_seq_id == 16'd0 && !res_one_step); // R7

  AST_ONESTEP_TYPE: assert property (@(posedge clk) disable iff (rst)
    res_valid && !res_error |-> res_one_step == (res_msg_type == 4'd0 || res_msg_type == 4'd3)); // R9

  AST_SINGLE_BYTE_SHORT: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_sof && in_eof |=> res_valid && res_error); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !res_valid); // R10
endmodule

bind ptp_hdr_extract ptp_hdr_extract_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .in_sof       (in_sof),
  .in_eof       (in_eof),
  .res_valid    (res_valid),
  .res_error    (res_error),
  .res_msg_type (res_msg_type),
  .res_clock_id (res_clock_id),
  .res_port_num (res_port_num),
  .res_seq_id   (res_seq_id),
  .res_one_step (res_one_step)
);

// File: tb/ptp_hdr_extract_bench.sv
`timescale 1ns/1ps
module ptp_hdr_extract_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_sof, in_eof, in_vlan;
  logic [7:0]  in_data;
  logic [1:0]  in_encap;
  logic        res_valid, res_error, res_one_step;
  logic [3:0]  res_msg_type;
  logic [63:0] res_clock_id;
  logic [15:0] res_port_num, res_seq_id;

  always #2.5 clk = ~clk;

  ptp_hdr_extract u_ptp_hdr_extract (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .in_data(in_data), .in_encap(in_encap), .in_vlan(in_vlan),
    .res_valid(res_valid), .res_error(res_error), .res_msg_type(res_msg_type),
    .res_clock_id(res_clock_id), .res_port_num(res_port_num),
    .res_seq_id(res_seq_id), .res_one_step(res_one_step)
  );

  int checks = 0, fails = 0;
  int edges = 0, got_cnt = 0, got_edge = 0, seed = 0;
  logic        g_err, g_one;
  logic [3:0]  g_msg;
  logic [63:0] g_clk;
  logic [15:0] g_port, g_seq;
  logic [7:0]  fb [0:255];

  always @(posedge clk) begin
    #1;
    edges++;
    if (res_valid) begin
      got_cnt++;
      got_edge = edges;
      g_err = res_error; g_one = res_one_step; g_msg = res_msg_type;
      g_clk = res_clock_id; g_port = res_port_num; g_seq = res_seq_id;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    end
  endtask

  // enc: 0 raw, 1 IPv4, 2 IPv6, 3 unknown
  task automatic run_frame(input int enc, input int vlan, input int ihl, input int msg,
                           input int len, input bit gap, input string req);
    int base, start, cidx, exp_edge;
    bit full;
    logic [3:0]  e_msg;
    logic [63:0] e_clk;
    logic [15:0] e_port, e_seq;
    base  = vlan ? 4 : 0;
    start = (enc == 0) ? base + 14 : (enc == 1) ? base + 22 + 4 * ihl :
            (enc == 2) ? base + 62 : -1;
    seed++;
    for (int i = 0; i < len; i++) fb[i] = 8'((i * 37 + seed * 11 + 5) & 255);
    if (enc == 1 && base + 14 < len) fb[base + 14] = 8'h40 | 8'(ihl);
    if (start >= 0 && start < len) fb[start] = {fb[start][7:4], 4'(msg)};
    full = (start >= 0) && (len >= start + 32);
    e_msg = 0; e_clk = 0; e_port = 0; e_seq = 0;
    if (full) begin
      e_msg = fb[start][3:0];
      for (int k = 0; k < 8; k++) e_clk = {e_clk[55:0], fb[start + 20 + k]};
      e_port = {fb[start + 28], fb[start + 29]};
      e_seq  = {fb[start + 30], fb[start + 31]};
    end
    cidx = full ? start + 31 : len - 1;
    exp_edge = 0;
    got_cnt = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sof   = (i == 0);
      in_eof   = (i == len - 1);
      in_data  = fb[i];
      in_encap = (i == 0) ? 2'(enc) : 2'(enc + i + 1);
      in_vlan  = (i == 0) ? vlan[0] : ~vlan[0];
      if (i == cidx) exp_edge = edges + 1;
      if (gap && (i % 3 == 1)) begin
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b1; in_eof = 1'b1; in_data = 8'hA5;
      end
    end
    idle(4);
    chk(got_cnt == 1, req, "result count", 64'(got_cnt), 64'd1);
    chk(got_edge == exp_edge, req, "strobe cycle", 64'(got_edge), 64'(exp_edge));
    chk(g_err == !full, req, "error flag", 64'(g_err), 64'(!full));
    chk(g_msg == e_msg && g_clk == e_clk, req, "msg/clock id (R5)",
        {g_msg, g_clk[59:0]}, {e_msg, e_clk[59:0]});
    chk(g_port == e_port && g_seq == e_seq, req, "port/seq (R5)",
        {g_port, g_seq}, {e_port, e_seq});
    chk(g_one == (full && (e_msg == 0 || e_msg == 3)), req, "one-step (R9)",
        64'(g_one), 64'(full && (e_msg == 0 || e_msg == 3)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 0; in_sof = 0; in_eof = 0; in_data = 0; in_encap = 0; in_vlan = 0;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(!res_valid && res_clock_id == 0 && res_seq_id == 0 && res_port_num == 0 &&
        res_msg_type == 0, "R11", "reset outputs", {res_valid, res_clock_id[62:0]}, 64'd0);
    rst = 1'b0;
    idle(2);
    // R1 R2 R4 raw and IPv6, both tag states, every message type
    for (int enc = 0; enc <= 2; enc += 2)
      for (int v = 0; v < 2; v++)
        for (int m = 0; m < 16; m++)
          run_frame(enc, v, 0, m, (enc == 0 ? 14 : 62) + 4 * v + 32 + (m % 4), m[0],
                    enc == 0 ? (v ? "R2" : "R1") : "R4");
    // R3 IPv4 with every header-length nibble
    for (int v = 0; v < 2; v++)
      for (int n = 0; n < 16; n++)
        run_frame(1, v, n, n, 22 + 4 * v + 4 * n + 32 + 2, n[0], "R3");
    // R7 R6 truncation sweep around the sequence id end
    for (int l = 1; l <= 53; l++) run_frame(0, 1, 0, 3, l, l[1], l < 50 ? "R7" : "R6");
    for (int l = 10; l <= 82; l++) run_frame(1, 0, 6, 0, l, 1'b0, l < 78 ? "R7" : "R6");
    // R8 unknown encapsulation
    for (int l = 1; l <= 120; l += 7) run_frame(3, l % 2, 5, 1, l, l[0], "R8");
    // R10 stray valid bytes outside any frame
    got_cnt = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = 1'b0; in_eof = (i % 2 == 1); in_data = 8'(i * 9);
    end
    idle(4);
    chk(got_cnt == 0, "R10", "stray bytes result count", 64'(got_cnt), 64'd0);
    run_frame(0, 0, 0, 2, 50, 1'b1, "R10");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule